// File: doc/BRIEF.md
# SPI-attached UART host sequencer

This block lets on-chip logic use an external UART that sits behind a 16-bit full-duplex SPI register interface. Every exchange with the device is one 16-bit frame: a 2-bit command goes out in the top bits while the device's status and data shift back at the same time. The block builds those frames itself, shifting bits on its own serial clock, so the user side sees only byte streams.

After reset the block programs the device's baud rate and reads the setting back. If the readback does not match, it waits and tries again, up to a bounded number of attempts. Once this is done it serves two byte streams. An outgoing byte waits until the device reports that its transmitter has room. Incoming bytes are fetched on demand into a local FIFO. A newline on the outgoing stream is expanded to carriage return plus newline.

Top module: `spi_uart_host`

## Requirements
- R1: A frame holds `spi_cs_n` low for exactly 16 `spi_sclk` pulses. The serial clock idles low. `spi_mosi` changes only while `spi_sclk` is low and carries the frame MSB first. `spi_miso` is sampled on each rising edge of `spi_sclk`.
- R2: Bits 15:14 of an outgoing frame are the command: 2'b11 config write, 2'b01 config read, 2'b10 data write, 2'b00 data read. Config-read and data-read frames carry zeros below bit 14.
- R3: After reset the block sends one config-write frame and then one config-read frame. If bits 13:0 of the reply equal the written value, `init_done` rises and `init_fail` stays low. Before `init_done`, `tx_ready` and `rx_valid` stay low.
- R4: The config word holds the baud code in bits 3:0 and zeros in bits 13:4. `baud_sel` values 0..9 pick 230400, 115200, 57600, 38400, 19200, 9600, 4800, 2400, 1200 and 600 baud. These map to codes 0, 1, 2, 9, 10, 11, 12, 13, 14 and 15, so selection s gives code s for s<=2 and s+6 for 3<=s<=9. Values 10..15 give code 1.
- R5: On a readback mismatch the block waits `GAP_CYCLES` clock cycles and repeats the write/read pair. After `MAX_TRIES` failed pairs it raises `init_fail` and `init_done` together and goes on to normal operation.
- R6: For each outgoing character the block sends config-read frames until bit 14 of a reply is set, then sends one data-write frame with the character in bits 7:0. `tx_ready` is then high for exactly one cycle, during which `tx_valid` is held.
- R7: An outgoing 0x0A is sent as a data-write of 0x0D followed by a data-write of 0x0A. `tx_ready` is asserted only after the second one.
- R8: When `rx_ready` is high, the FIFO is empty and no character is waiting to be sent, the block sends data-read frames. Each reply with bit 15 set pushes bits 7:0 into the FIFO. Reading stops at the first reply with bit 15 clear, or as soon as the FIFO holds `DEPTH` entries.
- R9: If the reply to a data-write frame has bit 15 set and the FIFO is not full, bits 7:0 of that reply are pushed into the FIFO.
- R10: `rx_valid` is high while the FIFO is non-empty and `rx_data` shows the oldest entry. An entry is removed on a clock edge with `rx_valid` and `rx_ready` both high. A push and a pop on the same edge both take effect, and arrival order is kept.
- R11: During reset `spi_cs_n` is high, `spi_sclk` is low, and `tx_ready`, `rx_valid`, `init_done` and `init_fail` are low. The FIFO is emptied when the init sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; init sequence starts on release |
| baud_sel | input | 4 | Baud rate selection index (see R4) |
| tx_data | input | 8 | Outgoing character |
| tx_valid | input | 1 | Outgoing character present; held until accepted |
| tx_ready | output | 1 | One-cycle acceptance of `tx_data` |
| rx_data | output | 8 | Oldest received character |
| rx_valid | output | 1 | Receive FIFO non-empty |
| rx_ready | input | 1 | Consumer takes `rx_data`; while the FIFO is empty, requests a fetch |
| init_done | output | 1 | Config sequence finished |
| init_fail | output | 1 | Config readback never matched |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
Two functions can meet on one clock edge: the push of a character carried in a data-write reply, and the consumer's pop of the FIFO head. The bench preloads the FIFO with three characters and queues one more in the device model. It then sends a byte, waits for the chip select of the data-write frame to rise, and raises `rx_ready` for the single cycle whose edge is the push edge. The outcome is judged from the ports: the popped byte must be the oldest preloaded one, and the following pops must return the other two and then the piggybacked character, with `rx_valid` falling after the last.

// File: rtl/suh_pkg.sv
package suh_pkg;
  localparam int FRAME_BITS = 16;
  localparam int RXA_BIT    = 15;  // reply: received character present
  localparam int TXR_BIT    = 14;  // reply: transmitter can take a character

  typedef enum logic [1:0] {
    CMD_RDATA = 2'b00,
    CMD_RCFG  = 2'b01,
    CMD_WDATA = 2'b10,
    CMD_WCFG  = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    S_INIT_WR, S_INIT_RD, S_GAP, S_IDLE,
    S_TX_POLL, S_TX_WRITE, S_RX_READ, S_RX_NEXT
  } state_e;

  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_CR = 8'h0D;
endpackage

// File: rtl/suh_baud_map.sv
module suh_baud_map (
  input  logic [3:0] sel,
  output logic [3:0] code
);
  always_comb begin
    if (sel <= 4'd2)      code = sel;
    else if (sel <= 4'd9) code = sel + 4'd6;
    else                  code = 4'd1;
  end
endmodule

// File: rtl/suh_frame_shifter.sv
module suh_frame_shifter #(
  parameter int HALF_DIV = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] word_out,
  output logic [15:0] word_in,
  output logic        done,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  import suh_pkg::*;
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);
  localparam logic [3:0]    BIT_LAST = 4'(FRAME_BITS - 1);

  logic          busy;
  logic [DW-1:0] div;
  logic [3:0]    bitn;
  logic [15:0]   sh_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0; mosi <= 1'b0; done <= 1'b0;
      div <= '0; bitn <= '0; sh_out <= '0; word_in <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; cs_n <= 1'b0; sh_out <= word_out; mosi <= word_out[15];
          div <= '0; bitn <= '0;
        end
      end else if (div != DIV_LAST) begin
        div <= div + 1'b1;
      end else begin
        div <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          word_in <= {word_in[14:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == BIT_LAST) begin
            busy <= 1'b0; cs_n <= 1'b1; done <= 1'b1; mosi <= 1'b0;
          end else begin
            bitn   <= bitn + 1'b1;
            sh_out <= {sh_out[14:0], 1'b0};
            mosi   <= sh_out[14];
          end
        end
      end
    end
  end
endmodule

// File: rtl/suh_rx_fifo.sv
module suh_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_uart_host.sv
module spi_uart_host #(
  parameter int DEPTH      = 16,
  parameter int HALF_DIV   = 50,
  parameter int GAP_CYCLES = 10000,
  parameter int MAX_TRIES  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] baud_sel,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       init_done,
  output logic       init_fail,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  import suh_pkg::*;
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES - 1);

  state_e        state;
  logic          launched, f_start, f_done;
  logic [15:0]   f_word, f_reply, issue_word;
  logic [13:0]   cfg_word;
  logic [3:0]    baud_code;
  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] tries;
  logic [7:0]    cur_char;
  logic          cr_done, rx_clr, rx_empty, rx_full, rx_push, rx_pop;
  logic          frame_state;

  suh_baud_map u_baud (.sel(baud_sel), .code(baud_code));

  suh_frame_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(f_start), .word_out(f_word), .word_in(f_reply),
    .done(f_done), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso));

  assign rx_push = f_done && f_reply[RXA_BIT] &&
                   ((state == S_TX_WRITE) || (state == S_RX_READ));
  assign rx_pop  = rx_valid && rx_ready;
  assign rx_valid = !rx_empty;

  suh_rx_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(rx_push), .din(f_reply[7:0]),
    .pop(rx_pop), .head(rx_data), .empty(rx_empty), .full(rx_full));

  always_comb begin
    frame_state = 1'b1;
    case (state)
      S_INIT_WR:  issue_word = {CMD_WCFG, 10'b0, baud_code};
      S_INIT_RD:  issue_word = {CMD_RCFG, 14'b0};
      S_TX_POLL:  issue_word = {CMD_RCFG, 14'b0};
      S_TX_WRITE: issue_word = {CMD_WDATA, 6'b0, cur_char};
      S_RX_READ:  issue_word = {CMD_RDATA, 14'b0};
      default: begin issue_word = '0; frame_state = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_INIT_WR; launched <= 1'b0; f_start <= 1'b0; f_word <= '0;
      cfg_word <= '0; gap_cnt <= '0; tries <= '0; cur_char <= '0; cr_done <= 1'b0;
      init_done <= 1'b0; init_fail <= 1'b0; tx_ready <= 1'b0; rx_clr <= 1'b0;
    end else begin
      f_start  <= 1'b0;
      tx_ready <= 1'b0;
      rx_clr   <= 1'b0;
      if (frame_state && !launched) begin
        f_start <= 1'b1; f_word <= issue_word; launched <= 1'b1;
        if (state == S_INIT_WR) cfg_word <= issue_word[13:0];
      end
      if (f_done) launched <= 1'b0;
      case (state)
        S_INIT_WR: if (f_done) state <= S_INIT_RD;
        S_INIT_RD: if (f_done) begin
          if (f_reply[13:0] == cfg_word) begin
            init_done <= 1'b1; rx_clr <= 1'b1; state <= S_IDLE;
          end else if (tries == TRY_LAST) begin
            init_done <= 1'b1; init_fail <= 1'b1; rx_clr <= 1'b1; state <= S_IDLE;
          end else begin
            tries <= tries + 1'b1; gap_cnt <= '0; state <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_LAST) state <= S_INIT_WR;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        S_IDLE: begin
          if (tx_valid && !tx_ready) begin
            cur_char <= (tx_data == CH_LF && !cr_done) ? CH_CR : tx_data;
            state    <= S_TX_POLL;
          end else if (rx_ready && rx_empty) begin
            state <= S_RX_READ;
          end
        end
        S_TX_POLL: if (f_done && f_reply[TXR_BIT]) state <= S_TX_WRITE;
        S_TX_WRITE: if (f_done) begin
          if (tx_data == CH_LF && !cr_done) cr_done <= 1'b1;
          else begin cr_done <= 1'b0; tx_ready <= 1'b1; end
          state <= S_IDLE;
        end
        S_RX_READ: if (f_done) state <= f_reply[RXA_BIT] ? S_RX_NEXT : S_IDLE;
        S_RX_NEXT: state <= rx_full ? S_IDLE : S_RX_READ;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_uart_host_chk.sv
module spi_uart_host_chk (
  input logic       clk,
  input logic       rst,
  input logic       init_done,
  input logic       init_fail,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi
);
  // R1
  cs_idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
  // R1
  mosi_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  // R3
  quiet_before_init_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (!tx_ready && !rx_valid));
  // R5
  fail_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
    init_fail |-> init_done);
  // R11
  init_done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  // R6
  tx_ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> !tx_ready);
  // R6
  tx_ready_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> tx_valid);
  // R10
  rx_head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_uart_host spi_uart_host_chk u_chk (
  .clk(clk), .rst(rst), .init_done(init_done), .init_fail(init_fail),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .spi_cs_n(spi_cs_n),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi));

// File: tb/spi_uart_host_bench.sv
`timescale 1ns/1ps
module spi_uart_host_bench;
  localparam int B_DEPTH = 16;
  localparam int B_HALF  = 2;
  localparam int B_GAP   = 20;
  localparam int B_TRIES = 5;
  localparam int FRAME_CYC = 2 * B_HALF * 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] baud_sel = 4'd1;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0;
  logic tx_ready, rx_valid, init_done, init_fail;
  logic [7:0] rx_data;
  logic rx_ready = 1'b0;
  logic spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  int vectors = 0;
  int fails   = 0;

  always #5 clk = ~clk;

  spi_uart_host #(.DEPTH(B_DEPTH), .HALF_DIV(B_HALF), .GAP_CYCLES(B_GAP),
                  .MAX_TRIES(B_TRIES)) u_spi_uart_host (
    .clk(clk), .rst(rst), .baud_sel(baud_sel), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .init_done(init_done),
    .init_fail(init_fail), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // ---------------- device model ----------------
  logic [13:0] m_cfg;
  logic [7:0]  m_q[$];
  logic [7:0]  m_log[$];
  int m_busy, m_busy_len, m_corrupt_left;
  bit m_corrupt_all, m_active, m_r_start;
  int m_bits, m_frame_err, n_wc, n_rc, n_wd, n_rd, m_early;
  logic [15:0] m_in, m_rc_rep, m_dt_rep;
  logic [1:0]  m_cmd;

  function automatic logic rep_bit(input int idx);
    if (m_bits >= 2 && m_cmd == 2'b01) return m_rc_rep[idx];
    return m_dt_rep[idx];
  endfunction

  always @(negedge spi_cs_n) begin
    m_active  = 1'b1;
    m_bits    = 0;
    m_in      = '0;
    m_cmd     = 2'b00;
    m_r_start = (m_q.size() > 0);
    m_rc_rep  = {m_r_start, m_busy == 0,
                 (m_corrupt_all || m_corrupt_left > 0) ? (m_cfg ^ 14'h0100) : m_cfg};
    m_dt_rep  = {m_r_start, m_busy == 0, 6'b0, m_r_start ? m_q[0] : 8'h00};
    spi_miso  = m_dt_rep[15];
  end

  always @(posedge spi_sclk) if (m_active) begin
    m_in = {m_in[14:0], spi_mosi};
    m_bits++;
    if (m_bits == 2) m_cmd = m_in[1:0];
  end

  always @(negedge spi_sclk) if (m_active && !spi_cs_n && m_bits < 16)
    spi_miso = rep_bit(15 - m_bits);

  always @(posedge spi_cs_n) if (m_active) begin
    m_active = 1'b0;
    if (m_bits != 16) m_frame_err++;
    case (m_in[15:14])
      2'b11: begin m_cfg = m_in[13:0]; n_wc++; end
      2'b01: begin
        n_rc++;
        if (m_busy > 0) m_busy--;
        if (m_corrupt_left > 0) m_corrupt_left--;
        if (m_in[13:0] != 14'h0) m_frame_err++;
      end
      2'b10: begin
        n_wd++;
        if (m_busy != 0) m_early++;
        m_log.push_back(m_in[7:0]);
        m_busy = m_busy_len;
        if (m_r_start) void'(m_q.pop_front());
      end
      default: begin
        n_rd++;
        if (m_in[13:0] != 14'h0) m_frame_err++;
        if (m_r_start) void'(m_q.pop_front());
      end
    endcase
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input int s);
    if (s <= 2) return 4'(s);
    if (s <= 9) return 4'(s + 6);
    return 4'd1;
  endfunction

  task automatic zero_counts();
    n_wc = 0; n_rc = 0; n_wd = 0; n_rd = 0; m_early = 0; m_frame_err = 0;
  endtask

  task automatic do_reset(input logic [3:0] sel, input int corrupt_n, input bit corrupt_all);
    @(negedge clk);
    rst = 1'b1; baud_sel = sel; tx_valid = 1'b0; rx_ready = 1'b0;
    m_q.delete(); m_log.delete(); m_cfg = '0; m_busy = 0; m_busy_len = 0;
    m_corrupt_left = corrupt_n; m_corrupt_all = corrupt_all; m_active = 1'b0;
    zero_counts();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R11 spi idle in reset",
        {spi_cs_n, spi_sclk}, 2'b10);
    chk(!tx_ready && !rx_valid && !init_done && !init_fail, "R11 user outputs in reset",
        {tx_ready, rx_valid, init_done, init_fail}, 0);
    rst = 1'b0;
  endtask

  task automatic wait_init(output int cyc);
    cyc = 0;
    while (!init_done) begin @(negedge clk); cyc++; end
  endtask

  task automatic send_byte(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1;
    do @(negedge clk); while (!tx_ready);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_byte(output logic [7:0] b);
    rx_ready = 1'b1;
    while (!rx_valid) @(negedge clk);
    b = rx_data;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic request_once();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=%0d cycles expected=fewer", 190000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int cyc;
    logic [7:0] got;
    logic [7:0] exp_log[$];

    m_busy = 0; m_busy_len = 0; m_corrupt_left = 0; m_corrupt_all = 0; m_active = 0;
    zero_counts();

    // R3 / R4 / R1 / R2: baud selection sweep
    for (int s = 0; s < 16; s++) begin
      do_reset(4'(s), 0, 1'b0);
      wait_init(cyc);
      chk(m_cfg == {10'b0, exp_code(s)}, "R4 config word", m_cfg, {10'b0, exp_code(s)});
      chk(n_wc == 1 && n_rc == 1, "R3 R2 one write one readback", n_wc * 16 + n_rc, 17);
      chk(!init_fail, "R3 no failure on match", init_fail, 0);
      chk(m_frame_err == 0, "R1 frame length and zero fill", m_frame_err, 0);
    end

    // R5: three mismatching readbacks, then success
    do_reset(4'd5, 3, 1'b0);
    wait_init(cyc);
    chk(n_wc == 4 && n_rc == 4, "R5 retry count", n_wc, 4);
    chk(!init_fail, "R5 recovered without failure", init_fail, 0);
    chk(cyc >= 3 * B_GAP + 8 * FRAME_CYC, "R5 gap between attempts", cyc, 3 * B_GAP + 8 * FRAME_CYC);

    // R5: never matches
    do_reset(4'd5, 0, 1'b1);
    wait_init(cyc);
    chk(n_wc == B_TRIES, "R5 attempt limit", n_wc, B_TRIES);
    chk(init_fail == 1'b1, "R5 failure flag", init_fail, 1);

    // R6 / R7: every byte value, transmitter busy for two polls after each write
    do_reset(4'd1, 0, 1'b0);
    wait_init(cyc);
    zero_counts();
    m_busy_len = 2;
    for (int b = 0; b < 256; b++) begin
      send_byte(8'(b));
      if (b == 8'h0A) exp_log.push_back(8'h0D);
      exp_log.push_back(8'(b));
    end
    chk(m_log.size() == 257, "R7 write count with newline expansion", m_log.size(), 257);
    for (int i = 0; i < 257; i++)
      if (i < m_log.size())
        chk(m_log[i] == exp_log[i], "R6 R7 written character", m_log[i], exp_log[i]);
    chk(m_early == 0, "R6 no write while busy", m_early, 0);
    chk(n_rc == 1 + 256 * 3, "R6 ready polls", n_rc, 1 + 256 * 3);
    chk(n_rd == 0 && m_frame_err == 0, "R1 R2 no stray frames", n_rd + m_frame_err, 0);

    // R8: fill stops at DEPTH entries
    do_reset(4'd1, 0, 1'b0);
    wait_init(cyc);
    zero_counts();
    for (int i = 0; i < 20; i++) m_q.push_back(8'(8'h30 + i));
    request_once();
    repeat (20 * (FRAME_CYC + 4)) @(negedge clk);
    chk(n_rd == B_DEPTH, "R8 reads stop when full", n_rd, B_DEPTH);
    chk(m_q.size() == 20 - B_DEPTH, "R8 device keeps the rest", m_q.size(), 20 - B_DEPTH);
    chk(rx_valid == 1'b1, "R10 data available", rx_valid, 1);
    for (int i = 0; i < B_DEPTH; i++) begin
      pop_byte(got);
      chk(got == 8'(8'h30 + i), "R10 FIFO order", got, 8'h30 + i);
    end
    chk(rx_valid == 1'b0, "R10 FIFO empty after draining", rx_valid, 0);

    // R8 / R10: consumer pops while reads continue; stops at empty reply
    zero_counts();
    for (int i = B_DEPTH; i < 20; i++) begin
      rx_ready = 1'b1;
      pop_byte(got);
      rx_ready = 1'b1;
      chk(got == 8'(8'h30 + i), "R10 order during fetch", got, 8'h30 + i);
    end
    rx_ready = 1'b0;
    repeat (4 * FRAME_CYC) @(negedge clk);
    chk(n_rd == 5, "R8 stops on empty reply", n_rd, 5);
    chk(rx_valid == 1'b0, "R8 nothing extra queued", rx_valid, 0);

    // R9 / R10: write-data reply pushes while the consumer pops on the same edge
    zero_counts();
    m_busy_len = 0;
    m_q.push_back(8'hA1); m_q.push_back(8'hA2); m_q.push_back(8'hA3);
    request_once();
    repeat (5 * (FRAME_CYC + 4)) @(negedge clk);
    chk(n_rd == 4, "R8 preload reads", n_rd, 4);
    m_q.push_back(8'h5A);
    tx_data = 8'h41; tx_valid = 1'b1;
    begin
      int wd0;
      wd0 = n_wd;
      do begin @(posedge spi_cs_n); #1; end while (n_wd == wd0);
    end
    @(negedge clk);
    rx_ready = 1'b1;
    got = rx_data;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(got == 8'hA1, "R10 pop on push edge", got, 8'hA1);
    chk(tx_ready == 1'b1, "R6 accept after write", tx_ready, 1);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(m_log.size() > 0 && m_log[m_log.size()-1] == 8'h41, "R6 character written",
        m_log.size() > 0 ? m_log[m_log.size()-1] : 0, 8'h41);
    pop_byte(got); chk(got == 8'hA2, "R10 order after overlap", got, 8'hA2);
    pop_byte(got); chk(got == 8'hA3, "R10 order after overlap", got, 8'hA3);
    pop_byte(got); chk(got == 8'h5A, "R9 piggybacked character", got, 8'h5A);
    chk(n_rd == 4, "R9 no extra read frames", n_rd, 4);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R9 FIFO empty at end", rx_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule